// File: doc/BRIEF.md
# GPIO Bank with Combined Interrupt

A bank of general-purpose pins, each governed by its own 8-bit setup register. The register picks the pin's direction and whether its value is inverted. It also decides whether the pin feeds a shared interrupt, whether the pin is handed over to an alternate on-chip function, and whether the interrupt path skips its debounce filter. Core logic supplies output data and reads input data over per-pin vectors. The pads see a data value and an output enable.

Every pin whose interrupt enable is set contributes a level to a single active-high interrupt line. Input pins contribute their synchronised, polarity-adjusted value. Output pins contribute the value they drive. Unless bypassed, each contribution first passes a debounce filter timed by a millisecond prescaler, so that glitches and switch bounce never reach the interrupt. One further register holds a channel number that is presented to the interrupt router outside this block. Register writes and reads take effect only while the configuration-mode input is high.

Top module: `gpio_bank`

## Requirements
- R1: Addresses 0..N_PORTS-1 select the per-pin setup registers, and address N_PORTS selects the channel register. A write happens on a clock edge with cfg_mode and reg_we high. reg_rdata shows the addressed register combinationally, and any other address reads 0.
- R2: Setup register bits 7:5 and channel register bits above CHAN_W always read 0, whatever was written.
- R3: After reset all registers are 0, pad_oe is 0, irq is 0 and irq_chan is 0. A pin's pad_oe stays 0 until its setup register has been written at least once.
- R4: Setup bit 0 is direction, with 1 meaning input and 0 meaning output. A written output pin drives pad_oe high, and an input pin never does.
- R5: For a non-alternate pin, pad_out equals gp_dout XOR setup bit 1 (the invert bit).
- R6: gp_din equals pad_in XOR setup bit 1, after a two-flop synchroniser, so a pad change appears on the second clock edge.
- R7: With setup bit 3 set (alternate), pad_out carries alt_in unchanged and ignores the invert bit. alt_out carries the synchronised pad value, and alt_out is 0 for pins without bit 3.
- R8: irq is a register holding the OR, across pins with setup bit 2 set, of each pin's interrupt source. An input pin's source is its gp_din value (its raw synchronised value when alternate), and an output pin's source is its pad_out value. With no bit 2 set, irq is 0 on the next cycle.
- R9: Unless bypassed, a source passes a debounce filter that accepts a new level only once the level has persisted through two ticks of a CYC_PER_MS prescaler. A pulse of CYC_PER_MS cycles or fewer never reaches irq, and a steady level reaches it within 2*CYC_PER_MS+4 cycles.
- R10: Setup bit 4 bypasses the filter, so irq follows an output source one edge later and an input pad three edges later.
- R11: irq_chan equals the low CHAN_W bits of the channel register, and it changes only on a write to that register.
- R12: With cfg_mode low, writes are ignored and reg_rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Enables register access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| pad_in | input | N_PORTS | Pad input levels |
| pad_out | output | N_PORTS | Pad output levels |
| pad_oe | output | N_PORTS | Pad output enables |
| gp_dout | input | N_PORTS | Core data for output pins |
| gp_din | output | N_PORTS | Core view of input pins |
| alt_in | input | N_PORTS | Alternate function drive |
| alt_out | output | N_PORTS | Alternate function receive |
| irq | output | 1 | Combined interrupt, active high |
| irq_chan | output | CHAN_W | Held interrupt channel number |

## Verification
A register write that removes one pin's interrupt enable can land on the same clock edge where another pin's source rises. The bench provokes this by issuing the write to an asserted input pin and raising a bypassed output pin's data in one cycle. It then checks cycle by cycle that irq never drops, because the old setup governs that edge and the new source takes over on the next. Finally it lowers the output pin's data and checks that irq falls, which shows that the disabled pin no longer contributes.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N_PORTS    = 4,
  parameter int CYC_PER_MS = 1000,
  parameter int CHAN_W     = 4,
  localparam int ADDR_W    = $clog2(N_PORTS + 1),
  localparam int PCW       = $clog2(CYC_PER_MS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [N_PORTS-1:0] pad_in,
  output logic [N_PORTS-1:0] pad_out,
  output logic [N_PORTS-1:0] pad_oe,
  input  logic [N_PORTS-1:0] gp_dout,
  output logic [N_PORTS-1:0] gp_din,
  input  logic [N_PORTS-1:0] alt_in,
  output logic [N_PORTS-1:0] alt_out,
  output logic               irq,
  output logic [CHAN_W-1:0]  irq_chan
);

  logic [N_PORTS-1:0][4:0] cfg;
  logic [N_PORTS-1:0]      written, sync1, sync2, filt, src;
  logic [N_PORTS-1:0]      dir_in, inv, ien, alt, byp;
  logic [N_PORTS-1:0][1:0] dcnt;
  logic [PCW-1:0]          pcnt;
  logic                    tick;
  logic [CHAN_W-1:0]       chan;
  logic                    irq_q;
  logic                    wr_ok;

  assign wr_ok = cfg_mode && reg_we;
  assign tick  = (pcnt == PCW'(CYC_PER_MS - 1));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign dir_in[i]  = cfg[i][0];
    assign inv[i]     = cfg[i][1];
    assign ien[i]     = cfg[i][2];
    assign alt[i]     = cfg[i][3];
    assign byp[i]     = cfg[i][4];
    assign pad_out[i] = alt[i] ? alt_in[i] : (gp_dout[i] ^ inv[i]);
    assign pad_oe[i]  = written[i] & ~dir_in[i];
    assign gp_din[i]  = sync2[i] ^ inv[i];
    assign alt_out[i] = alt[i] & sync2[i];
    assign src[i]     = dir_in[i] ? (alt[i] ? sync2[i] : gp_din[i]) : pad_out[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      written <= '0;
      chan    <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (reg_addr == ADDR_W'(i)) begin
          cfg[i]     <= reg_wdata[4:0];
          written[i] <= 1'b1;
        end
      end
      if (reg_addr == ADDR_W'(N_PORTS)) chan <= reg_wdata[CHAN_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = 8'd0;
    if (cfg_mode) begin
      for (int i = 0; i < N_PORTS; i++)
        if (reg_addr == ADDR_W'(i)) reg_rdata = {3'b000, cfg[i]};
      if (reg_addr == ADDR_W'(N_PORTS)) reg_rdata = 8'(chan);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      pcnt  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      pcnt  <= tick ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= '0;
      dcnt <= '0;
    end else begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (src[i] == filt[i]) begin
          dcnt[i] <= 2'd0;
        end else if (tick) begin
          if (dcnt[i] == 2'd1) begin
            filt[i] <= src[i];
            dcnt[i] <= 2'd0;
          end else begin
            dcnt[i] <= dcnt[i] + 2'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(ien & ((byp & src) | (~byp & filt)));
  end

  assign irq      = irq_q;
  assign irq_chan = chan;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_mode,
  input logic         reg_we,
  input logic [7:0]   reg_rdata,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] dir_in,
  input logic [N-1:0] ien,
  input logic         irq,
  input logic [CW-1:0] irq_chan
);

  // R12
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> reg_rdata == 8'd0);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_in) == '0);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien == '0 |=> !irq);

  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode && reg_we) |=> $stable(irq_chan));

endmodule

bind gpio_bank gpio_bank_chk #(.N(N_PORTS), .CW(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .pad_oe(pad_oe), .dir_in(dir_in), .ien(ien),
  .irq(irq), .irq_chan(irq_chan)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int CYC = 8;
  localparam int AW = $clog2(NP + 1);

  logic clk = 0, rst_n = 0, cfg_mode = 0, reg_we = 0, irq;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, gp_dout = '0, gp_din, alt_in = '0, alt_out;
  logic [3:0] irq_chan;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.N_PORTS(NP), .CYC_PER_MS(CYC), .CHAN_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gp_dout(gp_dout),
    .gp_din(gp_din), .alt_in(alt_in), .alt_out(alt_out), .irq(irq),
    .irq_chan(irq_chan));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_mode = 0; reg_we = 0; pad_in = '0; gp_dout = '0; alt_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_m(input bit mode, input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_mode = mode; reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0; cfg_mode = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_m(1'b1, a, d);
  endtask

  task automatic rd(input bit mode, input int a, output logic [7:0] v);
    @(negedge clk);
    cfg_mode = mode; reg_addr = AW'(a);
    #1 v = reg_rdata;
    cfg_mode = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk(pad_oe == 0, "R3 oe", 32'(pad_oe), 0);
    chk(irq == 0, "R3 irq", 32'(irq), 0);
    chk(irq_chan == 0, "R3 chan", 32'(irq_chan), 0);
    rd(1, 2, v);
    chk(v == 0, "R3 cfg", 32'(v), 0);
    wr(0, 8'h00);
    chk(pad_oe == 4'b0001, "R3 R4 oe after write", 32'(pad_oe), 1);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    do_reset();
    wr(0, 8'hFF);
    rd(1, 0, v);
    chk(v == 8'h1F, "R1 R2 port rd", 32'(v), 32'h1F);
    wr(NP, 8'hA5);
    rd(1, NP, v);
    chk(v == 8'h05, "R2 chan rd", 32'(v), 5);
    chk(irq_chan == 4'h5, "R11 chan out", 32'(irq_chan), 5);
    rd(1, NP + 1, v);
    chk(v == 0, "R1 unmapped", 32'(v), 0);
    wr_m(0, 0, 8'h00);
    wr_m(0, NP, 8'h03);
    rd(1, 0, v);
    chk(v == 8'h1F, "R12 write ignored", 32'(v), 32'h1F);
    chk(irq_chan == 4'h5, "R11 R12 chan kept", 32'(irq_chan), 5);
    rd(0, 0, v);
    chk(v == 0, "R12 read gated", 32'(v), 0);
  endtask

  task automatic t_output();
    do_reset();
    wr(1, 8'h00);
    gp_dout[1] = 1; #1;
    chk(pad_out[1] == 1, "R5 plain", 32'(pad_out[1]), 1);
    chk(pad_oe[1] == 1, "R4 output oe", 32'(pad_oe[1]), 1);
    wr(1, 8'h02); #1;
    chk(pad_out[1] == 0, "R5 inverted", 32'(pad_out[1]), 0);
  endtask

  task automatic t_input();
    wr(2, 8'h03);
    chk(pad_oe[2] == 0, "R4 input oe", 32'(pad_oe[2]), 0);
    pad_in[2] = 1;
    @(negedge clk);
    chk(gp_din[2] == 1, "R6 one edge", 32'(gp_din[2]), 1);
    @(negedge clk);
    chk(gp_din[2] == 0, "R6 two edges", 32'(gp_din[2]), 0);
  endtask

  task automatic t_alt();
    do_reset();
    wr(3, 8'h0A);
    alt_in[3] = 1; #1;
    chk(pad_out[3] == 1, "R7 alt drive", 32'(pad_out[3]), 1);
    alt_in[3] = 0; #1;
    chk(pad_out[3] == 0, "R7 alt drive low", 32'(pad_out[3]), 0);
    wr(3, 8'h0B);
    pad_in = 4'b1001;
    repeat (2) @(negedge clk);
    chk(alt_out[3] == 1, "R7 alt receive", 32'(alt_out[3]), 1);
    chk(alt_out[0] == 0, "R7 non-alt", 32'(alt_out[0]), 0);
    chk(pad_oe[3] == 0, "R4 alt input oe", 32'(pad_oe[3]), 0);
  endtask

  task automatic t_bypass();
    do_reset();
    wr(1, 8'h14);
    gp_dout[1] = 1;
    @(negedge clk);
    chk(irq == 1, "R8 R10 output src", 32'(irq), 1);
    gp_dout[1] = 0;
    @(negedge clk);
    chk(irq == 0, "R10 output src low", 32'(irq), 0);
    wr(1, 8'h16);
    @(negedge clk);
    chk(irq == 1, "R8 inverted output src", 32'(irq), 1);
    wr(1, 8'h10);
    wr(2, 8'h15);
    pad_in[2] = 1;
    repeat (2) @(negedge clk);
    chk(irq == 0, "R10 input two edges", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1, "R10 input three edges", 32'(irq), 1);
  endtask

  task automatic t_filter();
    bit seen;
    do_reset();
    wr(0, 8'h05);
    repeat (4 * CYC) @(negedge clk);
    chk(irq == 0, "R9 idle", 32'(irq), 0);
    seen = 0;
    pad_in[0] = 1;
    repeat (CYC) @(negedge clk);
    pad_in[0] = 0;
    for (int k = 0; k < 5 * CYC; k++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    chk(!seen, "R9 short pulse rejected", 32'(seen), 0);
    pad_in[0] = 1;
    repeat (2 * CYC + 4) @(negedge clk);
    chk(irq == 1, "R9 long level accepted", 32'(irq), 1);
    pad_in[0] = 0;
    repeat (2 * CYC + 4) @(negedge clk);
    chk(irq == 0, "R9 release accepted", 32'(irq), 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(0, 8'h15);
    wr(1, 8'h14);
    pad_in[0] = 1;
    repeat (4) @(negedge clk);
    chk(irq == 1, "R8 setup", 32'(irq), 1);
    cfg_mode = 1; reg_we = 1; reg_addr = AW'(0); reg_wdata = 8'h11; gp_dout[1] = 1;
    @(negedge clk);
    reg_we = 0; cfg_mode = 0;
    chk(irq == 1, "R8 old cfg edge", 32'(irq), 1);
    @(negedge clk);
    chk(irq == 1, "R8 handover", 32'(irq), 1);
    gp_dout[1] = 0;
    @(negedge clk);
    chk(irq == 0, "R8 disabled pin silent", 32'(irq), 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_output();
    t_input();
    t_alt();
    t_bypass();
    t_filter();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule